// File: doc/BRIEF.md
# Tuning Synthesizer Register Slave

This block is a write-only serial-bus slave that programs the control registers of a TV tuning synthesizer. It oversamples the two-wire bus (clock and data) with the system clock. It recognises START and STOP conditions and receives 8-bit bytes MSB first. On the ninth bus clock it pulls the data line low to acknowledge.

A transfer begins with an address byte of the form `11000 s1 s0 0`. The bits `s1 s0` come from the `addr_sel` input. The fixed address `0xC2` is accepted whatever `addr_sel` holds. The data bytes that follow identify themselves by their MSB.

- A byte with MSB 0 is the high part of the 15-bit divider word. The byte after it is the low part, and the whole word is committed only when that second byte arrives.
- A byte with MSB 1 is a control byte. The byte after it carries the four band-switch enables.

The divider pair and the control/band pair may be sent in either order within one transfer. A START or STOP at any point sends the byte sequencer back to expecting an address.

Two state machines do the work:

- **Link FSM**: states `L_IDLE`, `L_ADDR`, `L_ADDR_ACK`, `L_DATA`, `L_DATA_ACK`, `L_SKIP`.
  - START moves any state to `L_ADDR`, and STOP moves any state to `L_IDLE`.
  - `L_ADDR` goes to `L_ADDR_ACK` on a matching write address and to `L_SKIP` otherwise.
  - `L_DATA` goes to `L_DATA_ACK` after eight bits.
  - Both ack states return to `L_DATA` on the next SCL fall.
- **Decode FSM**: states `D_ANY`, `D_DIV_LO`, `D_BAND`.
  - `D_ANY` goes to `D_DIV_LO` on a byte with MSB 0 and to `D_BAND` on a byte with MSB 1.
  - Both `D_DIV_LO` and `D_BAND` return to `D_ANY` on the next byte.
  - START or STOP moves any decode state to `D_ANY`.

Top module: `tuner_i2c_regs`

## Requirements
- R1: An address byte equal to `{5'b11000, addr_sel, 1'b0}` is acknowledged: `sda_oe` is 1 during the high phase of the ninth SCL pulse.
- R2: The address byte `0xC2` is acknowledged for every value of `addr_sel`.
- R3: An address byte that matches neither address, or that has bit 0 (R/W) equal to 1, is not acknowledged. The data bytes that follow it in the same transfer are neither acknowledged nor decoded.
- R4: After an accepted address, every data byte is acknowledged on the ninth SCL pulse. `sda_oe` changes only while SCL is low.
- R5: A data byte with bit 7 = 0 (divider-high) followed by any byte sets `div_word = {first[6:0], second[7:0]}`. `div_word` changes only at the acknowledge of the second byte.
- R6: A STOP or repeated START after a divider-high byte leaves `div_word` unchanged. After a repeated START, the first data byte is again decoded by its MSB.
- R7: A data byte with bit 7 = 1 (control) sets, at its acknowledge, `cp_high` = bit 6, `test_bits` = bits 5:3, `ref_sel` = bits 2:1 and `tune_off` = bit 0. `cp_high` = 1 means the high pump current.
- R8: The byte after a control byte sets `band_en` = bits 3:0; bits 7:4 are ignored. `band_en[n]` = 1 turns band buffer n+1 on.
- R9: Within one transfer, the control/band pair may precede the divider pair, and both take effect.
- R10: After reset: `div_word` = 0, `cp_high` = 0, `test_bits` = 3'b001, `ref_sel` = 0, `tune_off` = 0, `band_en` = 0, `sda_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 2 | Selectable address bits s1 s0 |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| div_word | output | 15 | Programmable divider word |
| cp_high | output | 1 | Charge-pump current select, 1 = high |
| test_bits | output | 3 | Test mode bits |
| ref_sel | output | 2 | Reference divider ratio select |
| tune_off | output | 1 | 1 switches the tuning output off |
| band_en | output | 4 | Band-switch buffer enables |

## Verification
The hardest case to reach from the ports is a transfer cut short between the two divider bytes. The pending high byte must be discarded, and the decoder must not treat the next byte as the low half. The bench stops a transfer right after a divider-high byte. It then opens a second transfer, sends a divider-high byte and issues a repeated START. Only after that does it send a fresh divider pair. The resulting word shows whether the abandoned half leaked through.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] ADDR_PREFIX = 5'b11000;
    localparam logic [6:0] FIXED_ADDR = 7'b1100001;

    typedef enum logic [2:0] {
        L_IDLE,
        L_ADDR,
        L_ADDR_ACK,
        L_DATA,
        L_DATA_ACK,
        L_SKIP
    } link_state_t;

    typedef enum logic [1:0] {
        D_ANY,
        D_DIV_LO,
        D_BAND
    } dec_state_t;
endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        scl_s    = scl_pipe[STAGES-1];
        sda_s    = sda_pipe[STAGES-1];
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
    end
endmodule

// File: rtl/tuner_i2c_link.sv
module tuner_i2c_link
    import tuner_i2c_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_ev,
    input  logic                stop_ev,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda_s,
    input  logic [1:0]          addr_sel,
    output logic                sda_oe,
    output logic                data_stb,
    output logic [BYTE_W-1:0]   data_byte,
    output logic                seq_clear
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    link_state_t state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic byte_full, addr_ok, in_ack, in_rx;

    always_comb begin
        byte_full = (bit_cnt == CNT_W'(BYTE_W));
        addr_ok   = !shreg[0] &&
                    ((shreg[7:1] == {ADDR_PREFIX, addr_sel}) || (shreg[7:1] == FIXED_ADDR));
        in_ack    = (state == L_ADDR_ACK) || (state == L_DATA_ACK);
        in_rx     = (state == L_ADDR) || (state == L_DATA);
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            L_IDLE:     state_n = L_IDLE;
            L_ADDR:     if (scl_fall && byte_full) state_n = addr_ok ? L_ADDR_ACK : L_SKIP;
            L_ADDR_ACK: if (scl_fall) state_n = L_DATA;
            L_DATA:     if (scl_fall && byte_full) state_n = L_DATA_ACK;
            L_DATA_ACK: if (scl_fall) state_n = L_DATA;
            L_SKIP:     state_n = L_SKIP;
            default:    state_n = L_IDLE;
        endcase
        if (start_ev)     state_n = L_ADDR;
        else if (stop_ev) state_n = L_IDLE;
    end

    // state register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= L_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state <= state_n;
            if (start_ev || (scl_fall && in_ack)) begin
                bit_cnt <= '0;
            end else if (scl_rise && in_rx && !byte_full) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = in_ack;
        data_stb  = (state == L_DATA) && scl_fall && byte_full && !start_ev && !stop_ev;
        data_byte = shreg;
        seq_clear = start_ev | stop_ev;
    end
endmodule

// File: rtl/tuner_reg_decode.sv
module tuner_reg_decode
    import tuner_i2c_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int TEST_W = 3,
    parameter int REF_W  = 2,
    parameter int BAND_N = 4,
    parameter logic [TEST_W-1:0] TEST_RST = 3'b001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_clear,
    input  logic                data_stb,
    input  logic [BYTE_W-1:0]   data_byte,
    output logic [DIV_W-1:0]    div_word,
    output logic                cp_high,
    output logic [TEST_W-1:0]   test_bits,
    output logic [REF_W-1:0]    ref_sel,
    output logic                tune_off,
    output logic [BAND_N-1:0]   band_en
);
    localparam int HI_W    = DIV_W - BYTE_W;
    localparam int CP_POS  = BYTE_W - 2;
    localparam int TEST_LO = 1 + REF_W;
    localparam int TEST_HI = TEST_LO + TEST_W - 1;

    dec_state_t state, state_n;
    logic [HI_W-1:0] div_hi;
    logic is_ctrl;

    always_comb begin
        is_ctrl = data_byte[BYTE_W-1];
        state_n = state;
        unique case (state)
            D_ANY:    if (data_stb) state_n = is_ctrl ? D_BAND : D_DIV_LO;
            D_DIV_LO: if (data_stb) state_n = D_ANY;
            D_BAND:   if (data_stb) state_n = D_ANY;
            default:  state_n = D_ANY;
        endcase
        if (seq_clear) state_n = D_ANY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= D_ANY;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_hi    <= '0;
            div_word  <= '0;
            cp_high   <= 1'b0;
            test_bits <= TEST_RST;
            ref_sel   <= '0;
            tune_off  <= 1'b0;
            band_en   <= '0;
        end else if (data_stb && !seq_clear) begin
            unique case (state)
                D_ANY: begin
                    if (is_ctrl) begin
                        cp_high   <= data_byte[CP_POS];
                        test_bits <= data_byte[TEST_HI:TEST_LO];
                        ref_sel   <= data_byte[REF_W:1];
                        tune_off  <= data_byte[0];
                    end else begin
                        div_hi <= data_byte[HI_W-1:0];
                    end
                end
                D_DIV_LO: div_word <= {div_hi, data_byte};
                D_BAND:   band_en  <= data_byte[BAND_N-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tuner_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W  = 15,
    parameter int TEST_W = 3,
    parameter int REF_W  = 2,
    parameter int BAND_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    output logic              sda_oe,
    output logic [DIV_W-1:0]  div_word,
    output logic              cp_high,
    output logic [TEST_W-1:0] test_bits,
    output logic [REF_W-1:0]  ref_sel,
    output logic              tune_off,
    output logic [BAND_N-1:0] band_en
);
    logic sda_s, start_ev, stop_ev, scl_rise, scl_fall;
    logic data_stb, seq_clear;
    logic [BYTE_W-1:0] data_byte;

    tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    tuner_i2c_link u_link (
        .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .data_stb(data_stb),
        .data_byte(data_byte), .seq_clear(seq_clear)
    );

    tuner_reg_decode #(
        .DIV_W(DIV_W), .TEST_W(TEST_W), .REF_W(REF_W), .BAND_N(BAND_N)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .seq_clear(seq_clear), .data_stb(data_stb),
        .data_byte(data_byte), .div_word(div_word), .cp_high(cp_high),
        .test_bits(test_bits), .ref_sel(ref_sel), .tune_off(tune_off),
        .band_en(band_en)
    );
endmodule

// File: rtl/tuner_i2c_checker.sv
module tuner_i2c_checker #(
    parameter int DIV_W  = 15,
    parameter int TEST_W = 3,
    parameter int REF_W  = 2,
    parameter int BAND_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [DIV_W-1:0]  div_word,
    input logic              cp_high,
    input logic [TEST_W-1:0] test_bits,
    input logic [REF_W-1:0]  ref_sel,
    input logic              tune_off,
    input logic [BAND_N-1:0] band_en
);
    // R4: acknowledge is raised only while the bus clock is low
    p_ack_rise_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R4: data line drive is held while the bus clock stays high
    p_ack_hold_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R5: divider word only moves at an acknowledge
    p_div_at_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word) |-> sda_oe);

    // R7: control fields only move at an acknowledge
    p_ctrl_at_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cp_high, test_bits, ref_sel, tune_off}) |-> sda_oe);

    // R8: band enables only move at an acknowledge
    p_band_at_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_en) |-> sda_oe);
endmodule

bind tuner_i2c_regs tuner_i2c_checker #(
    .DIV_W(DIV_W), .TEST_W(TEST_W), .REF_W(REF_W), .BAND_N(BAND_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .div_word(div_word), .cp_high(cp_high), .test_bits(test_bits),
    .ref_sel(ref_sel), .tune_off(tune_off), .band_en(band_en)
);

// File: tb/sim_tuner_i2c_regs.sv
`timescale 1ns/1ps
module sim_tuner_i2c_regs;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic sda_oe, cp_high, tune_off;
    logic [14:0] div_word;
    logic [2:0] test_bits;
    logic [1:0] ref_sel;
    logic [3:0] band_en;
    logic sda_line;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    assign sda_line = sda_drv & ~sda_oe;

    always #10 clk = ~clk;

    tuner_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .div_word(div_word),
        .cp_high(cp_high), .test_bits(test_bits), .ref_sel(ref_sel),
        .tune_off(tune_off), .band_en(band_en)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl = 1'b1; wclk(HALF);
        sda_drv = 1'b0; wclk(HALF);
        scl = 1'b0; wclk(HALF);
    endtask

    task automatic bus_restart();
        sda_drv = 1'b1; wclk(HALF);
        scl = 1'b1; wclk(HALF);
        sda_drv = 1'b0; wclk(HALF);
        scl = 1'b0; wclk(HALF);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wclk(HALF);
        scl = 1'b1; wclk(HALF);
        sda_drv = 1'b1; wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(2);
            sda_drv = b[i]; wclk(HALF);
            scl = 1'b1; wclk(HALF);
            scl = 1'b0;
        end
        wclk(2);
        sda_drv = 1'b1; wclk(HALF);
        scl = 1'b1; wclk(HALF / 2);
        ack = sda_oe;
        wclk(HALF / 2);
        scl = 1'b0; wclk(HALF);
    endtask

    task automatic t_reset();
        check("R10 div", 32'(div_word), 32'h0);
        check("R10 cp", 32'(cp_high), 32'h0);
        check("R10 test", 32'(test_bits), 32'h1);
        check("R10 ref", 32'(ref_sel), 32'h0);
        check("R10 off", 32'(tune_off), 32'h0);
        check("R10 band", 32'(band_en), 32'h0);
        check("R10 sda_oe", 32'(sda_oe), 32'h0);
    endtask

    task automatic t_write_pairs();
        logic a;
        addr_sel = 2'b10;
        bus_start();
        send_byte(8'hC4, a); check("R1 own address ack", 32'(a), 32'h1);
        send_byte(8'h12, a); check("R4 divider-high ack", 32'(a), 32'h1);
        check("R5 div not yet committed", 32'(div_word), 32'h0);
        send_byte(8'h34, a); check("R4 divider-low ack", 32'(a), 32'h1);
        send_byte(8'hCE, a); check("R4 control ack", 32'(a), 32'h1);
        send_byte(8'hF5, a); check("R4 band ack", 32'(a), 32'h1);
        bus_stop();
        check("R5 div word", 32'(div_word), 32'h1234);
        check("R7 cp", 32'(cp_high), 32'h1);
        check("R7 test", 32'(test_bits), 32'h1);
        check("R7 ref", 32'(ref_sel), 32'h3);
        check("R7 off", 32'(tune_off), 32'h0);
        check("R8 band upper ignored", 32'(band_en), 32'h5);
    endtask

    task automatic t_fixed_reverse();
        logic a;
        addr_sel = 2'b11;
        bus_start();
        send_byte(8'hC2, a); check("R2 fixed address ack", 32'(a), 32'h1);
        send_byte(8'hB9, a);
        send_byte(8'h0A, a);
        send_byte(8'h55, a);
        send_byte(8'h66, a);
        bus_stop();
        check("R9 div after control pair", 32'(div_word), 32'h5566);
        check("R9 R7 cp", 32'(cp_high), 32'h0);
        check("R9 R7 test", 32'(test_bits), 32'h7);
        check("R9 R7 ref", 32'(ref_sel), 32'h0);
        check("R9 R7 off", 32'(tune_off), 32'h1);
        check("R9 R8 band", 32'(band_en), 32'hA);
    endtask

    task automatic t_reject();
        logic a;
        addr_sel = 2'b00;
        bus_start();
        send_byte(8'hC6, a); check("R3 foreign address nack", 32'(a), 32'h0);
        send_byte(8'h01, a); check("R3 data after nack", 32'(a), 32'h0);
        send_byte(8'h02, a);
        bus_stop();
        check("R3 div unchanged", 32'(div_word), 32'h5566);
        bus_start();
        send_byte(8'hC1, a); check("R3 read address nack", 32'(a), 32'h0);
        send_byte(8'h83, a); check("R3 data after read nack", 32'(a), 32'h0);
        bus_stop();
        check("R3 cp unchanged", 32'(cp_high), 32'h0);
        check("R3 test unchanged", 32'(test_bits), 32'h7);
    endtask

    task automatic t_abort();
        logic a;
        addr_sel = 2'b00;
        bus_start();
        send_byte(8'hC0, a); check("R1 own address sel 00", 32'(a), 32'h1);
        send_byte(8'h7F, a);
        bus_stop();
        check("R6 stop after high byte", 32'(div_word), 32'h5566);
        bus_start();
        send_byte(8'hC0, a);
        send_byte(8'h11, a);
        bus_restart();
        send_byte(8'hC0, a); check("R6 address after restart", 32'(a), 32'h1);
        check("R6 restart after high byte", 32'(div_word), 32'h5566);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        check("R6 fresh pair after restart", 32'(div_word), 32'h2233);
    endtask

    task automatic t_ctrl_only();
        logic a;
        addr_sel = 2'b01;
        bus_start();
        send_byte(8'hC2, a); check("R2 fixed with sel 01", 32'(a), 32'h1);
        send_byte(8'h80, a);
        bus_stop();
        check("R7 cp cleared", 32'(cp_high), 32'h0);
        check("R7 test cleared", 32'(test_bits), 32'h0);
        check("R7 off cleared", 32'(tune_off), 32'h0);
        check("R8 band kept without band byte", 32'(band_en), 32'hA);
        check("R5 div kept", 32'(div_word), 32'h2233);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_write_pairs();
        t_fixed_reverse();
        t_reject();
        t_abort();
        t_ctrl_only();
        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule